// File: doc/BRIEF.md
# Configurable UART Serial Frame Engine

This block is the serial core of a UART: a bit-rate generator, a transmitter that turns one byte at a time into an asynchronous frame on a single output line, and a 16x oversampling receiver that turns line activity back into characters. A 16-bit mode word picks the character length, the number of stop bits and the parity. A 16-bit divider value picks the bit rate. The surrounding logic hands bytes to the transmitter with a valid/ready pair. It takes received characters from a single result word, which stays held until the consumer pulses an acknowledge.

Each received character comes back as a 13-bit tagged word. The word holds the data and one flag each for a parity mismatch, an overwritten unread result, a bad stop bit and a line break, plus a valid marker. The transmitter can be held off by a clear-to-send input when the mode word asks for it. A separate control input pulls the line low to send a break.

The engine runs on one clock that serves as the reference. One bit lasts 16 × (divider + 1) clock cycles. Mode fields are taken at the start of each frame, so a change in the middle of a frame affects only the next one.

Top module: `uart_frame_engine`

## Requirements
- R1: One bit period on the line equals 16 × (divider + 1) clock cycles, with the divider read from the 16-bit `baud_div` input.
- R2: A transmitted frame is one low start bit, then the data bits least significant first, then an optional parity bit, then the high stop bit(s). Mode bit 0 = 1 sends 7 data bits and ignores `tx_data[7]`. Mode bit 0 = 0 sends 8 data bits.
- R3: Parity is enabled by mode bit 4, and mode bit 3 selects its sense. Bits 4:3 = 10 give even parity, where the data plus the parity bit hold an even number of ones. Bits 4:3 = 11 give odd parity. Bits 4:3 = 00 send and expect no parity bit.
- R4: Mode bit 2 = 0 gives one stop bit and mode bit 2 = 1 gives two. The transmitter returns to idle after the last stop bit.
- R5: When mode bit 6 is set, a new frame starts only while `cts` is high, and `tx_ready` stays low while `cts` is low. When mode bit 6 is clear, `cts` has no effect.
- R6: While `brk_force` is high, `txd` is low regardless of the transmitter state. `txd` follows the frame again once `brk_force` falls.
- R7: `tx_idle` is high exactly when no frame is being shifted out. After reset, `tx_idle` = 1, `txd` = 1 and `rx_word` = 0.
- R8: A received character appears on `rx_word` with the data in bits 7:0 and bit 12 set as the valid marker. In 7-bit mode, bit 7 reads 0.
- R9: Bit 10 (framing error) is set when the first stop bit samples low and the character is not a break.
- R10: Bit 11 (break) is set when every data bit, the parity bit (if enabled) and the first stop bit all sample low. A break word has bits 10 and 8 clear.
- R11: Bit 8 (parity error) is set when parity is enabled and the received parity bit does not match the selected sense.
- R12: A one-cycle `rx_consume` pulse clears bit 12. A character that completes while bit 12 is still set replaces the word and sets bit 9 (overrun).
- R13: The receiver confirms a start bit only if the line is still low at the eighth 16x sample after the falling edge. A shorter low pulse produces no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_word | input | 16 | Frame format and flow-control selection |
| baud_div | input | 16 | Bit-rate divider value |
| brk_force | input | 1 | Holds the transmit line low while high |
| cts | input | 1 | Clear-to-send permission for new frames |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmitter accepts the offered byte this cycle |
| txd | output | 1 | Serial transmit line |
| tx_idle | output | 1 | No frame being shifted out |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_consume | input | 1 | Acknowledges the held received word |
| rx_word | output | 13 | Received character with status flags |

## Verification
The bench aims at the frame-length corners. A 7-bit frame whose parity bit is 1 shows up a receiver that takes an eighth data bit, because that bit would leak into data bit 7. A one-stop frame checked for idle before a second stop could end shows up a transmitter that always sends two stops. An all-low frame in odd-parity mode must report only a break: a design that ranks framing or parity above break would set bits 10 or 8. A second character that arrives before the first is acknowledged must carry the overrun flag, and a short low glitch must not start a frame. The random loopback runs across divider values 0 to 3 and mixed formats, so an off-by-one divider shifts the mid-bit samples and corrupts the compared frames.

// File: rtl/uart_fe_pkg.sv
// Shared definitions for the UART frame engine: oversampling constants,
// the decoded mode fields and the positions of the received-word flags.
// Assumes a 16-bit mode word whose unused bits are don't-care.
package uart_fe_pkg;

    localparam int OVS     = 16;
    localparam int SUB_W   = $clog2(OVS);
    localparam int WORD_W  = 13;
    localparam int B_PE    = 8;
    localparam int B_OVR   = 9;
    localparam int B_FE    = 10;
    localparam int B_BRK   = 11;
    localparam int B_VLD   = 12;

    typedef struct packed {
        logic cts_gate;
        logic par_en;
        logic par_odd;
        logic two_stop;
        logic seven;
    } fmt_t;

    // Pick the format fields out of the mode word.
    function automatic fmt_t decode_fmt(input logic [15:0] w);
        fmt_t f;
        f.seven    = w[0];
        f.two_stop = w[2];
        f.par_odd  = w[3];
        f.par_en   = w[4];
        f.cts_gate = w[6];
        return f;
    endfunction

endpackage

// File: rtl/uart_baud_tick.sv
// Oversampling strobe generator: one-cycle tick every (div+1) clocks, giving
// 16 ticks per bit. Assumes div is changed only while the line is quiet.
module uart_baud_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    // Count clocks up to the divider and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    p_wrap_after_overshoot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt > div) |=> (cnt == '0));
    p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/uart_tx_core.sv
// Frame serializer: start bit, LSB-first data, optional parity, 1 or 2 stop
// bits, 16 ticks per bit. Format is latched on acceptance. Break forcing
// overrides the line without disturbing the frame state.
module uart_tx_core
    import uart_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  fmt_t       fmt,
    input  logic       brk_force,
    input  logic       cts,
    input  logic [7:0] data,
    input  logic       valid,
    output logic       ready,
    output logic       txd,
    output logic       idle
);
    typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tst_t;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

    tst_t             st;
    logic [SUB_W-1:0] sub;
    logic [2:0]       bidx;
    logic [7:0]       shreg;
    logic             par_acc;
    logic             stop_more;
    fmt_t             fm;
    logic             line;
    logic [2:0]       last_idx;

    assign last_idx = fm.seven ? 3'd6 : 3'd7;
    assign ready    = (st == T_IDLE) && (!fmt.cts_gate || cts);
    assign idle     = (st == T_IDLE);
    assign txd      = brk_force ? 1'b0 : line;

    // Line level for the current frame position.
    always_comb begin
        case (st)
            T_START: line = 1'b0;
            T_DATA:  line = shreg[0];
            T_PAR:   line = par_acc ^ fm.par_odd;
            default: line = 1'b1;
        endcase
    end

    // Frame sequencer: accept a byte, then step one bit every 16 ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= T_IDLE; sub <= '0; bidx <= '0; shreg <= '0;
            par_acc <= 1'b0; stop_more <= 1'b0; fm <= '0;
        end else if (st == T_IDLE) begin
            if (valid && ready) begin
                shreg <= data; fm <= fmt; sub <= '0; bidx <= '0;
                par_acc <= 1'b0; st <= T_START;
            end
        end else if (tick) begin
            if (sub != SUB_LAST) begin
                sub <= sub + 1'b1;
            end else begin
                sub <= '0;
                case (st)
                    T_START: st <= T_DATA;
                    T_DATA: begin
                        par_acc <= par_acc ^ shreg[0];
                        shreg   <= {1'b0, shreg[7:1]};
                        if (bidx == last_idx) begin
                            st        <= fm.par_en ? T_PAR : T_STOP;
                            stop_more <= fm.two_stop;
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                    end
                    T_PAR: begin
                        st        <= T_STOP;
                        stop_more <= fm.two_stop;
                    end
                    default: begin
                        if (stop_more) stop_more <= 1'b0;
                        else           st <= T_IDLE;
                    end
                endcase
            end
        end
    end

    p_cts_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == T_START && $past(st == T_IDLE) && fm.cts_gate) |-> $past(cts));
    p_bit_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == T_DATA) |-> (bidx <= last_idx));
    p_start_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == T_START) |-> !txd);
endmodule

// File: rtl/uart_rx_core.sv
// Oversampling deserializer: synchronizes the line, confirms the start bit at
// the eighth tick, samples each later bit 16 ticks apart and builds the
// tagged result word. The format is latched when a start edge is seen.
module uart_rx_core
    import uart_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              seven,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rxd,
    input  logic              consume,
    output logic [WORD_W-1:0] word
);
    typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rst_t;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
    localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);

    rst_t             st;
    logic [SUB_W-1:0] sub;
    logic [2:0]       bidx;
    logic [7:0]       dat;
    logic             s1, s2, armed, ones, par_acc, perr;
    logic             r_seven, r_par_en, r_odd;
    logic             brk_c;

    assign brk_c = !ones && !s2;

    // Two-stage synchronizer for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin s1 <= 1'b1; s2 <= 1'b1; end
        else        begin s1 <= rxd;  s2 <= s1;   end
    end

    // Receive sequencer and result-word holder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= R_IDLE; sub <= '0; bidx <= '0; dat <= '0; armed <= 1'b0;
            ones <= 1'b0; par_acc <= 1'b0; perr <= 1'b0; word <= '0;
            r_seven <= 1'b0; r_par_en <= 1'b0; r_odd <= 1'b0;
        end else begin
            if (consume) word[B_VLD] <= 1'b0;
            if (tick) begin
                case (st)
                    R_IDLE: begin
                        if (s2) armed <= 1'b1;
                        else if (armed) begin
                            st <= R_START; sub <= '0;
                            r_seven <= seven; r_par_en <= par_en; r_odd <= par_odd;
                        end
                    end
                    R_START: begin
                        if (sub != SUB_MID) sub <= sub + 1'b1;
                        else if (!s2) begin
                            st <= R_DATA; sub <= '0; bidx <= '0; dat <= '0;
                            ones <= 1'b0; par_acc <= 1'b0; perr <= 1'b0;
                        end else st <= R_IDLE;
                    end
                    default: begin
                        if (sub != SUB_LAST) sub <= sub + 1'b1;
                        else begin
                            sub <= '0;
                            case (st)
                                R_DATA: begin
                                    dat[bidx] <= s2;
                                    ones      <= ones | s2;
                                    par_acc   <= par_acc ^ s2;
                                    if (bidx == (r_seven ? 3'd6 : 3'd7))
                                        st <= r_par_en ? R_PAR : R_STOP;
                                    else
                                        bidx <= bidx + 1'b1;
                                end
                                R_PAR: begin
                                    ones <= ones | s2;
                                    perr <= par_acc ^ s2 ^ r_odd;
                                    st   <= R_STOP;
                                end
                                default: begin
                                    word  <= {1'b1, brk_c, !s2 && !brk_c,
                                              word[B_VLD] && !consume,
                                              perr && !brk_c, dat};
                                    st    <= R_IDLE;
                                    armed <= 1'b0;
                                end
                            endcase
                        end
                    end
                endcase
            end
        end
    end

    p_break_excludes_fe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        word[B_BRK] |-> (!word[B_FE] && !word[B_PE]));
    p_valid_from_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word[B_VLD]) |-> $past(st == R_STOP && tick));
    p_consume_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && st != R_STOP) |=> !word[B_VLD]);
    p_start_confirm_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (st == R_DATA && $past(st == R_START)) |-> $past(!s2));
endmodule

// File: rtl/uart_frame_engine.sv
// Top of the UART frame engine: bit-rate tick generator, transmitter and
// receiver sharing one decoded mode word. Assumes rxd is asynchronous and
// that baud_div changes only between frames.
module uart_frame_engine
    import uart_fe_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       mode_word,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              brk_force,
    input  logic              cts,
    input  logic [7:0]        tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd,
    output logic              tx_idle,
    input  logic              rxd,
    input  logic              rx_consume,
    output logic [WORD_W-1:0] rx_word
);
    fmt_t fmt;
    logic tick;
    logic unused_mode_bits;

    assign fmt = decode_fmt(mode_word);
    assign unused_mode_bits = ^{mode_word[15:7], mode_word[5], mode_word[1]};

    uart_baud_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
    );

    uart_tx_core u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fmt(fmt),
        .brk_force(brk_force), .cts(cts), .data(tx_data), .valid(tx_valid),
        .ready(tx_ready), .txd(txd), .idle(tx_idle)
    );

    uart_rx_core u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .seven(fmt.seven),
        .par_en(fmt.par_en), .par_odd(fmt.par_odd), .rxd(rxd),
        .consume(rx_consume), .word(rx_word)
    );

    p_break_line_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_force |-> !txd);
endmodule

// File: tb/uart_frame_engine_test.sv
module uart_frame_engine_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mode_w = '0;
    logic [15:0] div_w = 16'd1;
    logic        brk = 1'b0, cts = 1'b0, tx_valid = 1'b0, rx_consume = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        rx_drv = 1'b1, loop = 1'b0;
    logic        tx_ready, txd, tx_idle;
    logic [12:0] rx_word;
    wire         rxd = loop ? txd : rx_drv;
    int          n_cmp = 0, n_mis = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_frame_engine uut (
        .clk(clk), .rst_n(rst_n), .mode_word(mode_w), .baud_div(div_w),
        .brk_force(brk), .cts(cts), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .txd(txd), .tx_idle(tx_idle), .rxd(rxd),
        .rx_consume(rx_consume), .rx_word(rx_word)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_mis++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int bit_clks();
        return 16 * (int'(div_w) + 1);
    endfunction

    // Frame bits, LSB first: start, data, optional parity, stop(s).
    function automatic logic [11:0] mk_frame(input logic [7:0] d, input logic [15:0] m, output int n);
        logic [11:0] f = '1;
        int k = 0;
        int nd = m[0] ? 7 : 8;
        logic p = 1'b0;
        f[k] = 1'b0; k++;
        for (int i = 0; i < nd; i++) begin f[k] = d[i]; p ^= d[i]; k++; end
        if (m[4]) begin f[k] = p ^ m[3]; k++; end
        f[k] = 1'b1; k++;
        if (m[2]) begin f[k] = 1'b1; k++; end
        n = k;
        return f;
    endfunction

    function automatic logic [12:0] mk_word(input logic [7:0] d, input bit brk_f, input bit fe, input bit ovr, input bit pe);
        return {1'b1, brk_f, fe, ovr, pe, d};
    endfunction

    // Offer a byte, capture the frame at mid-bit, check format and stop/idle timing.
    task automatic tx_capture(input logic [7:0] d, input string tag);
        logic [11:0] exp, cap;
        int n, guard;
        exp = mk_frame(d, mode_w, n);
        cap = '1;
        @(negedge clk); tx_data = d; tx_valid = 1'b1;
        guard = 0;
        while (!tx_ready && guard < 5000) begin @(negedge clk); guard++; end
        @(posedge clk); @(negedge clk); tx_valid = 1'b0;
        guard = 0;
        while (txd && guard < 200) begin @(negedge clk); guard++; end
        wait_clks(8 * (int'(div_w) + 1));
        for (int i = 0; i < n; i++) begin
            cap[i] = txd;
            if (i == n - 1 && mode_w[2])
                chk(tx_idle == 1'b0, "R4 busy during second stop", 32'(tx_idle), 32'd0);
            if (i < n - 1) wait_clks(bit_clks());
        end
        chk(((cap ^ exp) & 12'((1 << n) - 1)) == '0, {"R1 R2 R3 frame ", tag}, 32'(cap), 32'(exp));
        wait_clks(12 * (int'(div_w) + 1));
        chk(tx_idle == 1'b1 && txd == 1'b1, "R4 R7 idle after last stop", 32'({tx_idle, txd}), 32'b11);
    endtask

    // Drive a frame onto the receive line, then two idle bit times.
    task automatic rx_send(input logic [11:0] f, input int n);
        for (int i = 0; i < n; i++) begin rx_drv = f[i]; wait_clks(bit_clks()); end
        rx_drv = 1'b1;
        wait_clks(2 * bit_clks());
    endtask

    task automatic consume_chk(input string tag);
        @(negedge clk); rx_consume = 1'b1;
        @(negedge clk); rx_consume = 1'b0;
        chk(rx_word[12] == 1'b0, {"R12 consume clears valid ", tag}, 32'(rx_word), 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_mis++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end

    initial begin
        logic [11:0] f;
        logic [7:0]  d;
        logic [15:0] m;
        int n;
        void'($urandom(32'd1357));
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(2);
        // R7 reset state
        chk(tx_idle && txd && rx_word == '0 && tx_ready, "R7 reset state",
            32'({tx_idle, txd, tx_ready, rx_word}), 32'({3'b111, 13'd0}));

        // R6 forced break while idle, then release
        brk = 1'b1; wait_clks(5);
        chk(txd == 1'b0, "R6 break forces line low", 32'(txd), 32'd0);
        brk = 1'b0; @(negedge clk);
        chk(txd == 1'b1, "R6 line released", 32'(txd), 32'd1);

        // Random loopback across formats and dividers; cts low with gating off (R5)
        loop = 1'b1;
        for (int it = 0; it < 16; it++) begin
            div_w = 16'($urandom_range(0, 3));
            m = '0;
            m[0] = 1'($urandom); m[2] = 1'($urandom);
            m[3] = 1'($urandom); m[4] = 1'($urandom);
            mode_w = m;
            d = 8'($urandom);
            wait_clks(2 * bit_clks());
            tx_capture(d, "random");
            chk(rx_word == mk_word(m[0] ? {1'b0, d[6:0]} : d, 0, 0, 0, 0), "R8 loopback word",
                32'(rx_word), 32'(mk_word(m[0] ? {1'b0, d[6:0]} : d, 0, 0, 0, 0)));
            consume_chk("loop");
        end

        // R5 CTS gating holds off a frame
        div_w = 16'd1; mode_w = 16'h0040; cts = 1'b0;
        @(negedge clk); tx_data = 8'hA5; tx_valid = 1'b1;
        wait_clks(200);
        chk(tx_idle && txd && !tx_ready, "R5 held while cts low", 32'({tx_idle, txd, tx_ready}), 32'b110);
        cts = 1'b1;
        tx_capture(8'hA5, "cts");
        chk(rx_word[7:0] == 8'hA5, "R5 R8 frame after cts", 32'(rx_word), 32'h10A5);
        consume_chk("cts");
        cts = 1'b0;

        // Directed receive cases on the driven line
        loop = 1'b0; div_w = 16'd1;
        wait_clks(2 * bit_clks());

        // R8: 7-bit, even parity, parity bit 1 must not leak into data bit 7
        mode_w = 16'h0011;
        f = mk_frame(8'h54, mode_w, n); rx_send(f, n);
        chk(rx_word == mk_word(8'h54, 0, 0, 0, 0), "R8 seven-bit data bit7 zero", 32'(rx_word), 32'(mk_word(8'h54, 0, 0, 0, 0)));
        consume_chk("7bit");

        // R11: odd parity with flipped parity bit
        mode_w = 16'h0018;
        f = mk_frame(8'hA3, mode_w, n); f[9] = ~f[9]; rx_send(f, n);
        chk(rx_word == mk_word(8'hA3, 0, 0, 0, 1), "R11 parity error", 32'(rx_word), 32'(mk_word(8'hA3, 0, 0, 0, 1)));
        consume_chk("par");

        // R9: stop bit low, data nonzero
        mode_w = 16'h0000;
        f = mk_frame(8'h3C, mode_w, n); f[9] = 1'b0; rx_send(f, n);
        chk(rx_word == mk_word(8'h3C, 0, 1, 0, 0), "R9 framing error", 32'(rx_word), 32'(mk_word(8'h3C, 0, 1, 0, 0)));
        consume_chk("fe");

        // R10: all-low frame in odd parity mode reports only break
        mode_w = 16'h0018;
        rx_send(12'h000, 11);
        chk(rx_word == mk_word(8'h00, 1, 0, 0, 0), "R10 break word", 32'(rx_word), 32'(mk_word(8'h00, 1, 0, 0, 0)));
        consume_chk("brk");

        // R12: second character before consume sets overrun
        mode_w = 16'h0000;
        f = mk_frame(8'h11, mode_w, n); rx_send(f, n);
        f = mk_frame(8'h22, mode_w, n); rx_send(f, n);
        chk(rx_word == mk_word(8'h22, 0, 0, 1, 0), "R12 overrun", 32'(rx_word), 32'(mk_word(8'h22, 0, 0, 1, 0)));
        consume_chk("ovr");

        // R13: short low glitch produces no word, real frame still received
        rx_drv = 1'b0; wait_clks(4 * (int'(div_w) + 1)); rx_drv = 1'b1;
        wait_clks(3 * bit_clks());
        chk(rx_word[12] == 1'b0, "R13 glitch ignored", 32'(rx_word), 32'd0);
        f = mk_frame(8'h69, mode_w, n); rx_send(f, n);
        chk(rx_word == mk_word(8'h69, 0, 0, 0, 0), "R13 frame after glitch", 32'(rx_word), 32'(mk_word(8'h69, 0, 0, 0, 0)));

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule